// File: doc/BRIEF.md
# Sequenced-Refresh Watchdog Timer

This block guards a processor against a hung or runaway program. Software controls it through one 8-bit control and status register on a simple write/read bus. Once software enables the block, a 16-bit counter advances on each pulse of a periodic time-base strobe. If software does not refresh the counter before it reaches the selected limit, the block issues a one-cycle system-reset request.

A refresh counts only when it arrives as two register writes in a fixed order. The first write sets the arm bit. A later write then sets the confirm bit. A confirm bit on its own is ignored. This makes it unlikely that a single stray store keeps a broken program alive.

A sticky flag records that a timeout happened. The flag survives the reset that the block itself requests, so software can learn after restart why it restarted. An external reset on `rst_n` clears the flag. The limit is `BASE_TICKS << sel`, where `sel` is a 3-bit field. With a 1 ms strobe and the default base of 16, this gives 16 ms to 2048 ms.

Top module: `seqref_watchdog`

## Requirements
- R1: The register reads as {sel[2:0] at bits 7:5, 0 at bit 4, arm-pending at bit 3, 0 at bit 2, timeout flag at bit 1, enable at bit 0}. A write loads sel and enable from the same positions.
- R2: After `rst_n` is low, the register reads 0x00, and `wdt_reset_req` is low.
- R3: While enabled, once the counter has reached `BASE_TICKS << sel`, `wdt_reset_req` is high on the next cycle, for exactly one cycle.
- R4: While disabled, the counter stays at zero and no reset request is issued, however many ticks arrive.
- R5: A write that changes enable from 0 to 1 starts counting from zero. Disabling and then re-enabling restarts the full interval.
- R6: A write with bit 3 set marks a refresh as pending. A later write with bit 2 set while a refresh is pending clears the counter, and the pending bit then reads 0.
- R7: A write with bit 2 set when no refresh is pending is ignored: the counter keeps running, and the request comes at the original time.
- R8: On a timeout, the flag is set in the same cycle as the request. Enable, sel and the pending bit return to 0.
- R9: Writing 0 to bit 1 clears the flag. Writing 1 to bit 1 never sets it; only a timeout does.
- R10: An external reset on `rst_n` clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External active-low reset; clears everything, including the flag |
| tick | input | 1 | Time-base strobe; the counter advances by one per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value (combinational from state) |
| wdt_reset_req | output | 1 | One-cycle system-reset request |

## Verification
A write takes effect at the clock edge that samples `wr_en`, and `rd_data` shows the new value right after that edge. The bench therefore drives at the falling edge and reads back at the next falling edge. After the enabling or refreshing edge, the counter reaches the limit L after L ticked edges. The request appears one edge later, so with `tick` held high it is first seen on the (L+1)-th falling-edge sample. The bench counts samples from the write and compares against L+1, L+1 minus the ticks already spent, or no request at all. It also checks that the request has dropped on the next sample.

// File: rtl/seqref_watchdog.sv
module seqref_watchdog #(
  parameter int CNT_W      = 16,
  parameter int BASE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_reset_req
);

  logic [2:0]       sel;
  logic             en, pend, flag;
  logic [CNT_W-1:0] count, limit;
  logic             expire, refresh, arm;

  assign limit   = CNT_W'(BASE_TICKS) << sel;
  assign expire  = en && (count >= limit);
  assign refresh = wr_en && wr_data[2] && pend;
  assign arm     = wr_en && wr_data[0] && !en;
  assign rd_data = {sel, 1'b0, pend, 1'b0, flag, en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= '0; en <= 1'b0; pend <= 1'b0; flag <= 1'b0;
      count <= '0; wdt_reset_req <= 1'b0;
    end else if (expire) begin
      wdt_reset_req <= 1'b1;
      flag  <= 1'b1;
      sel   <= '0;
      en    <= 1'b0;
      pend  <= 1'b0;
      count <= '0;
    end else begin
      wdt_reset_req <= 1'b0;
      if (wr_en) begin
        sel <= wr_data[7:5];
        en  <= wr_data[0];
        if (!wr_data[1]) flag <= 1'b0;
        if (refresh) pend <= 1'b0;
        else if (wr_data[3]) pend <= 1'b1;
      end
      if (!en || arm || refresh) count <= '0;
      else if (tick) count <= count + 1'b1;
    end
  end

  // R3
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |=> !wdt_reset_req);

  // R8
  req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_reset_req |-> (flag && !en && sel == 3'd0 && !pend));

  // R9
  flag_only_by_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> wdt_reset_req);

  // R4
  disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wdt_reset_req);

endmodule

// File: tb/tb_seqref_watchdog.sv
`timescale 1ns/1ps
module tb_seqref_watchdog;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wdt_reset_req;
  int checks = 0, errors = 0, cyc = 0;

  seqref_watchdog dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .wdt_reset_req(wdt_reset_req));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam int NV = 4;
  localparam int VSEL [NV] = '{0, 1, 2, 3};
  localparam int VEXP [NV] = '{17, 33, 65, 129};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_req(input int maxn, output int n);
    n = 0;
    for (int i = 1; i <= maxn; i++) begin
      @(negedge clk);
      if (wdt_reset_req) begin n = i; break; end
    end
  endtask

  task automatic run_ticks(input int k);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ext_reset();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    int n;
    repeat (2) @(negedge clk);
    // R2 reset state
    chk("R2 reset read", rd_data, 8'h00);
    chk("R2 reset req", wdt_reset_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table: timeout interval per sel, with tick held high
    for (int v = 0; v < NV; v++) begin
      wr(8'((VSEL[v] << 5) | 1));
      chk("R1 sel/en readback", rd_data, (VSEL[v] << 5) | 1);
      tick = 1'b1;
      wait_req(300, n);
      chk("R3 timeout cycle", n, VEXP[v]);
      chk("R8 flag set, fields cleared", rd_data, 8'h02);
      @(negedge clk);
      chk("R3 request one cycle", wdt_reset_req, 0);
      tick = 1'b0;
      wr(8'h00);
      chk("R9 flag cleared by 0", rd_data, 8'h00);
    end

    // R9 writing 1 to flag has no effect
    wr(8'h02);
    chk("R9 write 1 ignored", rd_data, 8'h00);

    // R6 valid refresh
    wr(8'h01);
    run_ticks(10);
    wr(8'h09);
    chk("R6 pending reads 1", rd_data, 8'h09);
    wr(8'h05);
    chk("R6 pending cleared", rd_data, 8'h01);
    tick = 1'b1;
    wait_req(100, n);
    chk("R6 refresh restarts interval", n, 17);
    tick = 1'b0;
    wr(8'h00);

    // R7 confirm without arm ignored
    wr(8'h01);
    run_ticks(10);
    wr(8'h05);
    tick = 1'b1;
    wait_req(100, n);
    chk("R7 lone confirm ignored", n, 7);
    tick = 1'b0;
    wr(8'h00);

    // R7 reversed order is not a refresh
    wr(8'h01);
    run_ticks(10);
    wr(8'h05);
    wr(8'h09);
    tick = 1'b1;
    wait_req(100, n);
    chk("R7 reversed order ignored", n, 7);
    tick = 1'b0;
    wr(8'h00);

    // R4 disabled: no request
    tick = 1'b1;
    wait_req(300, n);
    chk("R4 disabled no request", n, 0);
    tick = 1'b0;

    // R5 disable then re-enable restarts
    wr(8'h01);
    run_ticks(12);
    wr(8'h00);
    wr(8'h01);
    tick = 1'b1;
    wait_req(100, n);
    chk("R5 re-enable restarts count", n, 17);
    tick = 1'b0;

    // R10 external reset clears flag
    chk("R10 flag set before reset", rd_data, 8'h02);
    ext_reset();
    chk("R10 flag cleared by rst_n", rd_data, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule